// File: doc/BRIEF.md
# Flash Access Timing and Prefetch Controller

This block sits between a multi-master bus and a flash array. It holds one 32-bit timing and policy register. Each accepted request is sequenced against the array with a programmable number of wait cycles, one count for reads and another for writes. A separate setting fixes the minimum spacing between back-to-back accepted requests, or turns overlap off entirely. On each accepted read the block also decides whether to ask a prefetch engine for the following line. That decision depends on a per-master enable mask and on separate policies for instruction and data reads.

Requests use a valid/ready handshake. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. The requester must hold its fields stable while `req_valid` is high and `req_ready` is low. `req_ready` does not depend on `req_valid`, and back-pressure comes only from `req_ready`. Completion is reported by a one-cycle `rsp_valid`, which has no back-pressure. The prefetch request is also a one-cycle strobe, `pf_valid`, with `pf_addr`, and it has no back-pressure either. Register writes through `cfg_we` take effect on the next edge. Every access uses the register contents captured on the edge that accepted it.

Top module: `flash_tpc`

## Requirements
- R1: After reset the register is all zero. `req_ready` is high, `arr_rd`, `arr_wr` and `pf_valid` are low, and no read triggers a prefetch until the register is written.
- R2: The read wait count is in bits [10:8]. A read with code n holds `arr_rd` for n+1 cycles, and `rsp_valid` is high in the last of them.
- R3: The write wait count is in bits [13:12]. Codes 1, 2 and 3 hold `arr_wr` for 2, 3 and 4 cycles. The reserved code 0 behaves as code 3.
- R4: The spacing field is in bits [18:16]. With a code h from 1 to 6, the next request is accepted no sooner than h+1 cycles after the previous accept, and it may be accepted in the completing cycle of the current access.
- R5: With spacing code 7, or the reserved code 0, `req_ready` stays low for the whole access, including its completing cycle. The next request is accepted in the cycle after completion.
- R6: The master enable mask is in bits [4:0], where bit i enables master i. A master with a clear bit, or any master ID of 5 to 7, never triggers a prefetch.
- R7: The data policy is in bits [21:20] and the instruction policy is in bits [25:24]. In each, 00 gives no prefetch, 01 allows bursts only, 11 allows any read, and the reserved 10 gives no prefetch. Each access type uses only its own field.
- R8: A write never triggers a prefetch.
- R9: `pf_valid` is a single-cycle pulse in the cycle after the accepting edge. `pf_addr` is the 32-byte line of the request address plus one line, wrapping at the top of the address space, with bits [4:0] equal to zero.
- R10: A register write that lands during an access does not change that access's wait count. A write on the same edge as an accept applies from the next access on.
- R11: During an access `arr_addr` holds the accepted address. Only the strobe that matches the access direction is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write enable |
| cfg_wdata | input | 32 | Register write value |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted |
| req_master | input | 3 | Requesting master ID |
| req_write | input | 1 | 1 = write, 0 = read |
| req_instr | input | 1 | 1 = instruction fetch, 0 = data |
| req_burst | input | 1 | Burst qualifier |
| req_addr | input | 32 | Byte address |
| arr_rd | output | 1 | Array read strobe, high for the whole access |
| arr_wr | output | 1 | Array write strobe, high for the whole access |
| arr_addr | output | 32 | Address presented to the array |
| rsp_valid | output | 1 | Access completes this cycle |
| pf_valid | output | 1 | Prefetch request pulse |
| pf_addr | output | 32 | Next-line address for the prefetch |

## Verification
The hardest situation to reach from the ports is a register change that arrives while an access is still counting its wait cycles. The stimulus runs a long read and, in a parallel thread, rewrites the register a few cycles into it. It then checks that the strobe length follows the old code and that the following access follows the new one. The same-edge case is driven by raising `cfg_we` and `req_valid` together. Overlap spacing is reached by holding `req_valid` high across two requests and timing the cycles between accepts.

// File: rtl/flash_tpc_pkg.sv
package flash_tpc_pkg;

  localparam int NUM_MST = 5;
  localparam int WS_W    = 3;

  localparam int MASK_LSB = 0;
  localparam int RWS_LSB  = 8;
  localparam int WWS_LSB  = 12;
  localparam int SPC_LSB  = 16;
  localparam int DPOL_LSB = 20;
  localparam int IPOL_LSB = 24;

  typedef enum logic [1:0] {
    POL_OFF   = 2'b00,
    POL_BURST = 2'b01,
    POL_RSVD  = 2'b10,
    POL_ANY   = 2'b11
  } pf_pol_e;

  typedef struct packed {
    logic [NUM_MST-1:0] mask;
    logic [WS_W-1:0]    rd_ws;
    logic [1:0]         wr_ws;
    logic [WS_W-1:0]    hold;
    logic               pipe_en;
    pf_pol_e            ipol;
    pf_pol_e            dpol;
  } timing_t;

  // Reserved codes fall back to the most conservative behaviour.
  function automatic pf_pol_e safe_pol(input logic [1:0] code);
    return (code == POL_RSVD) ? POL_OFF : pf_pol_e'(code);
  endfunction

  function automatic timing_t decode_cfg(input logic [31:0] r);
    timing_t t;
    t.mask    = r[MASK_LSB +: NUM_MST];
    t.rd_ws   = r[RWS_LSB +: WS_W];
    t.wr_ws   = (r[WWS_LSB +: 2] == 2'b00) ? 2'b11 : r[WWS_LSB +: 2];
    t.hold    = r[SPC_LSB +: WS_W];
    t.pipe_en = (r[SPC_LSB +: WS_W] != '0) && (r[SPC_LSB +: WS_W] != '1);
    t.ipol    = safe_pol(r[IPOL_LSB +: 2]);
    t.dpol    = safe_pol(r[DPOL_LSB +: 2]);
    return t;
  endfunction

endpackage

// File: rtl/flash_tpc_cfg.sv
module flash_tpc_cfg
  import flash_tpc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [31:0] cfg_wdata,
  output timing_t     eff
);

  logic [31:0] cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_wdata;
  end

  assign eff = decode_cfg(cfg_q);

endmodule

// File: rtl/flash_tpc_seq.sv
module flash_tpc_seq #(
  parameter int ADDR_W = 32,
  parameter int CW     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CW-1:0]     rd_ws,
  input  logic [1:0]        wr_ws,
  input  logic [CW-1:0]     hold,
  input  logic              pipe_en,
  output logic              req_ready,
  output logic              acc,
  output logic              arr_rd,
  output logic              arr_wr,
  output logic [ADDR_W-1:0] arr_addr,
  output logic              rsp_valid
);

  localparam logic [CW-1:0] GAP_MAX = '1;

  logic              busy_q, wr_q, pipe_q;
  logic [CW-1:0]     cnt_q, hold_q, gap_q;
  logic [ADDR_W-1:0] addr_q;
  logic              last, spaced;
  logic [CW-1:0]     wait_sel;

  always_comb begin
    last      = busy_q && (cnt_q == '0);
    spaced    = gap_q > hold_q;
    req_ready = pipe_q ? ((!busy_q || last) && spaced) : !busy_q;
    acc       = req_valid && req_ready;
    wait_sel  = req_write ? CW'(wr_ws) : rd_ws;
  end

  // Timing settings are captured at the accept edge and hold for the access.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      wr_q   <= 1'b0;
      pipe_q <= 1'b0;
      cnt_q  <= '0;
      hold_q <= '0;
      gap_q  <= GAP_MAX;
      addr_q <= '0;
    end else if (acc) begin
      busy_q <= 1'b1;
      cnt_q  <= wait_sel;
      wr_q   <= req_write;
      addr_q <= req_addr;
      hold_q <= hold;
      pipe_q <= pipe_en;
      gap_q  <= CW'(1);
    end else begin
      if (last)        busy_q <= 1'b0;
      else if (busy_q) cnt_q  <= cnt_q - CW'(1);
      if (gap_q != GAP_MAX) gap_q <= gap_q + CW'(1);
    end
  end

  assign arr_rd    = busy_q && !wr_q;
  assign arr_wr    = busy_q && wr_q;
  assign arr_addr  = addr_q;
  assign rsp_valid = last;

endmodule

// File: rtl/flash_tpc_pf.sv
module flash_tpc_pf
  import flash_tpc_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int MID_W   = 3,
  parameter int LINE_LG = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      acc,
  input  logic                      req_write,
  input  logic                      req_instr,
  input  logic                      req_burst,
  input  logic [MID_W-1:0]          req_master,
  input  logic [ADDR_W-LINE_LG-1:0] req_line,
  input  logic [NUM_MST-1:0]        mask,
  input  pf_pol_e                   ipol,
  input  pf_pol_e                   dpol,
  output logic                      pf_valid,
  output logic [ADDR_W-1:0]         pf_addr
);

  localparam int LW = ADDR_W - LINE_LG;

  logic          mst_ok, pol_ok, pf_q;
  pf_pol_e       pol;
  logic [LW-1:0] line_q;

  always_comb begin
    mst_ok = 1'b0;
    for (int i = 0; i < NUM_MST; i++)
      if (req_master == MID_W'(i)) mst_ok = mask[i];
    pol    = req_instr ? ipol : dpol;
    pol_ok = (pol == POL_ANY) || ((pol == POL_BURST) && req_burst);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pf_q   <= 1'b0;
      line_q <= '0;
    end else begin
      pf_q <= acc && !req_write && mst_ok && pol_ok;
      if (acc) line_q <= req_line + LW'(1);
    end
  end

  assign pf_valid = pf_q;
  assign pf_addr  = {line_q, {LINE_LG{1'b0}}};

endmodule

// File: rtl/flash_tpc.sv
module flash_tpc
  import flash_tpc_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int MID_W   = 3,
  parameter int LINE_LG = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [31:0]       cfg_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [MID_W-1:0]  req_master,
  input  logic              req_write,
  input  logic              req_instr,
  input  logic              req_burst,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              arr_rd,
  output logic              arr_wr,
  output logic [ADDR_W-1:0] arr_addr,
  output logic              rsp_valid,
  output logic              pf_valid,
  output logic [ADDR_W-1:0] pf_addr
);

  timing_t eff;
  logic    acc;

  flash_tpc_cfg u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .eff       (eff)
  );

  flash_tpc_seq #(.ADDR_W(ADDR_W), .CW(WS_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .rd_ws     (eff.rd_ws),
    .wr_ws     (eff.wr_ws),
    .hold      (eff.hold),
    .pipe_en   (eff.pipe_en),
    .req_ready (req_ready),
    .acc       (acc),
    .arr_rd    (arr_rd),
    .arr_wr    (arr_wr),
    .arr_addr  (arr_addr),
    .rsp_valid (rsp_valid)
  );

  flash_tpc_pf #(.ADDR_W(ADDR_W), .MID_W(MID_W), .LINE_LG(LINE_LG)) u_pf (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc        (acc),
    .req_write  (req_write),
    .req_instr  (req_instr),
    .req_burst  (req_burst),
    .req_master (req_master),
    .req_line   (req_addr[ADDR_W-1:LINE_LG]),
    .mask       (eff.mask),
    .ipol       (eff.ipol),
    .dpol       (eff.dpol),
    .pf_valid   (pf_valid),
    .pf_addr    (pf_addr)
  );

endmodule

// File: rtl/flash_tpc_sva.sv
module flash_tpc_sva #(
  parameter int ADDR_W  = 32,
  parameter int MID_W   = 3,
  parameter int LINE_LG = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [MID_W-1:0]  req_master,
  input logic              req_write,
  input logic              arr_rd,
  input logic              arr_wr,
  input logic [ADDR_W-1:0] arr_addr,
  input logic              rsp_valid,
  input logic              pf_valid,
  input logic [ADDR_W-1:0] pf_addr
);

  p_one_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(arr_rd && arr_wr));

  p_addr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_rd || arr_wr) && !rsp_valid |=> $stable(arr_addr));

  p_done_in_access_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (arr_rd || arr_wr));

  p_strobe_runs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_rd || arr_wr) && !rsp_valid |=> (arr_rd || arr_wr));

  p_ready_last_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready && (arr_rd || arr_wr) |-> rsp_valid);

  p_pf_after_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> $past(req_valid && req_ready && !req_write));

  p_pf_master_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> (int'($past(req_master)) < 5));

  p_pf_aligned_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> (pf_addr[LINE_LG-1:0] == '0));

  p_pf_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |=> !pf_valid);

endmodule

bind flash_tpc flash_tpc_sva #(.ADDR_W(ADDR_W), .MID_W(MID_W), .LINE_LG(LINE_LG)) u_sva (.*);

// File: tb/flash_tpc_tb.sv
`timescale 1ns/1ps
module flash_tpc_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_master = '0;
  logic        req_write = 1'b0, req_instr = 1'b0, req_burst = 1'b0;
  logic [31:0] req_addr = '0;
  logic        arr_rd, arr_wr, rsp_valid, pf_valid;
  logic [31:0] arr_addr, pf_addr;

  int     n_chk = 0, n_bad = 0;
  longint cyc = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  flash_tpc u_dut (.*);

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int mask, rws, wws, spc, dpol, ipol);
    return 32'(mask) | (32'(rws) << 8) | (32'(wws) << 12) | (32'(spc) << 16)
         | (32'(dpol) << 20) | (32'(ipol) << 24);
  endfunction

  task automatic wcfg(input logic [31:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // One access; starts and ends just after a falling edge.
  task automatic issue(input logic [2:0] m, input bit w, i, b, input logic [31:0] a,
                       output int len, output bit pf, output logic [31:0] pfa,
                       output bit bad);
    int g;
    req_master = m; req_write = w; req_instr = i; req_burst = b; req_addr = a;
    req_valid = 1'b1;
    g = 0;
    while (!req_ready && g < 50) begin @(negedge clk); g++; end
    @(negedge clk);
    req_valid = 1'b0;
    pf = pf_valid; pfa = pf_addr; len = 0; bad = 1'b0;
    g = 0;
    while (g < 50) begin
      if (arr_rd || arr_wr) len++;
      if ((arr_rd || arr_wr) && arr_addr !== a) bad = 1'b1;
      if (w ? arr_rd : arr_wr) bad = 1'b1;
      if (rsp_valid) break;
      @(negedge clk); g++;
    end
    @(negedge clk);
  endtask

  task automatic settle();
    repeat (8) @(negedge clk);
  endtask

  // Two reads with req_valid held; returns cycles between the accepts.
  task automatic b2b(output longint gap, output bit rdy_busy);
    int n, g;
    longint first;
    req_master = 0; req_write = 0; req_instr = 0; req_burst = 0; req_addr = 32'h40;
    req_valid = 1'b1; n = 0; g = 0; first = 0; gap = -1; rdy_busy = 1'b0;
    while (n < 2 && g < 60) begin
      if (req_ready && (arr_rd || arr_wr)) rdy_busy = 1'b1;
      if (req_ready) begin
        if (n == 0) first = cyc; else gap = cyc - first;
        n++;
      end
      @(negedge clk); g++;
    end
    req_valid = 1'b0;
    settle();
  endtask

  task automatic t_reset();
    int len; bit pf, bad; logic [31:0] pfa;
    chk("R1 ready", req_ready, 1);
    chk("R1 strobes", arr_rd | arr_wr, 0);
    chk("R1 pf", pf_valid, 0);
    issue(0, 0, 1, 1, 32'h100, len, pf, pfa, bad);
    chk("R1 no pf after reset", pf, 0);
    chk("R2 zero wait read", len, 1);
    issue(0, 1, 0, 0, 32'h100, len, pf, pfa, bad);
    chk("R3 reserved write code", len, 4);
  endtask

  task automatic t_read_waits();
    int len; bit pf, bad; logic [31:0] pfa;
    for (int n = 0; n < 8; n++) begin
      wcfg(mk(0, n, 1, 7, 0, 0));
      issue(1, 0, 0, 0, 32'h2000 + 32'(n * 4), len, pf, pfa, bad);
      chk($sformatf("R2 read code %0d", n), len, n + 1);
      chk("R11 addr/strobe", bad, 0);
    end
  endtask

  task automatic t_write_waits();
    int len; bit pf, bad; logic [31:0] pfa;
    for (int c = 0; c < 4; c++) begin
      wcfg(mk(5'h1F, 0, c, 7, 3, 3));
      issue(2, 1, c[0], 1, 32'h3000 + 32'(c * 64), len, pf, pfa, bad);
      chk($sformatf("R3 write code %0d", c), len, (c == 0) ? 4 : c + 1);
      chk("R8 write no pf", pf, 0);
      chk("R11 write strobe", bad, 0);
    end
  endtask

  task automatic t_pipelined();
    longint gap; bit rb;
    for (int h = 1; h <= 6; h++) begin
      wcfg(mk(0, 0, 1, h, 0, 0));
      settle();
      b2b(gap, rb);
      chk($sformatf("R4 spacing %0d", h), gap, h + 1);
    end
    wcfg(mk(0, 5, 1, 3, 0, 0));
    settle();
    b2b(gap, rb);
    chk("R4 accept in final cycle", gap, 6);
    chk("R4 ready during access", rb, 1);
  endtask

  task automatic t_no_pipe();
    longint gap; bit rb;
    int codes[2] = '{7, 0};
    foreach (codes[k]) begin
      wcfg(mk(0, 2, 1, codes[k], 0, 0));
      settle();
      b2b(gap, rb);
      chk($sformatf("R5 gap code %0d", codes[k]), gap, 4);
      chk("R5 ready low while busy", rb, 0);
    end
  endtask

  task automatic t_mask();
    int len; bit pf, bad; logic [31:0] pfa;
    wcfg(mk(5'h15, 0, 1, 7, 0, 3));
    for (int m = 0; m < 8; m++) begin
      issue(3'(m), 0, 1, 0, 32'h500, len, pf, pfa, bad);
      chk($sformatf("R6 master %0d", m), pf, (m < 5 && m % 2 == 0) ? 1 : 0);
    end
  endtask

  task automatic t_policy();
    int len; bit pf, bad; logic [31:0] pfa;
    for (int i = 0; i < 2; i++)
      for (int p = 0; p < 4; p++) begin
        wcfg(i ? mk(5'h1F, 0, 1, 7, 0, p) : mk(5'h1F, 0, 1, 7, p, 0));
        for (int b = 0; b < 2; b++) begin
          issue(4, 0, i[0], b[0], 32'h600, len, pf, pfa, bad);
          chk($sformatf("R7 instr=%0d pol=%0d burst=%0d", i, p, b), pf,
              (p == 3 || (p == 1 && b == 1)) ? 1 : 0);
        end
      end
  endtask

  task automatic t_pf_addr();
    int len; bit pf, bad; logic [31:0] pfa;
    wcfg(mk(5'h1F, 3, 1, 7, 3, 3));
    issue(0, 0, 0, 0, 32'h1000_0044, len, pf, pfa, bad);
    chk("R9 pf in first cycle", pf, 1);
    chk("R9 next line", pfa, 32'h1000_0060);
    issue(1, 0, 1, 1, 32'hFFFF_FFF0, len, pf, pfa, bad);
    chk("R9 wrap", pfa, 32'h0);
  endtask

  task automatic t_cfg_boundary();
    int len; bit pf, bad; logic [31:0] pfa;
    wcfg(mk(0, 6, 1, 7, 0, 0));
    fork
      issue(0, 0, 0, 0, 32'h700, len, pf, pfa, bad);
      begin
        repeat (3) @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = mk(0, 0, 1, 7, 0, 0);
        @(negedge clk);
        cfg_we = 1'b0;
      end
    join
    chk("R10 mid-access write ignored", len, 7);
    issue(0, 0, 0, 0, 32'h700, len, pf, pfa, bad);
    chk("R10 new code next access", len, 1);
    wcfg(mk(0, 2, 1, 7, 0, 0));
    cfg_we = 1'b1; cfg_wdata = mk(0, 5, 1, 7, 0, 0);
    fork
      issue(0, 0, 0, 0, 32'h740, len, pf, pfa, bad);
      begin @(negedge clk); cfg_we = 1'b0; end
    join
    chk("R10 same-edge write uses old", len, 3);
    issue(0, 0, 0, 0, 32'h740, len, pf, pfa, bad);
    chk("R10 same-edge write later", len, 6);
  endtask

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read_waits();
    t_write_waits();
    t_pipelined();
    t_no_pipe();
    t_mask();
    t_policy();
    t_pf_addr();
    t_cfg_boundary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule